// File: doc/BRIEF.md
# Single-precision compare and convert unit

This unit takes single-precision floating-point operands as raw 32-bit patterns. It either compares two of them, converts one of them to a 32-bit or 64-bit integer, or copies the bits of one of them into an integer register. Each request is presented for one clock cycle with a valid strobe. The 64-bit integer result appears one cycle later, together with an invalid-operation flag and an inexact flag for that request.

The three compares are equality, less-than and less-or-equal, and each returns 0 or 1. They differ in how they treat NaN operands. Equality is quiet: it raises invalid only for a signaling NaN. The two ordering compares raise invalid for any NaN.

Conversions truncate toward zero. Results that cannot be represented saturate, and NaN inputs and negative-to-unsigned inputs return fixed values. Two sticky flag bits collect the invalid and inexact events of every accepted request since reset.

Top module: `fcc_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, out_result, out_nv, out_nx, sticky_nv and sticky_nx are all 0.
- R2: Operation codes on in_op:
  - 0 is equality.
  - 1 is less-than.
  - 2 is less-or-equal.
  - 3 converts to signed 32-bit.
  - 4 converts to unsigned 32-bit.
  - 5 converts to signed 64-bit.
  - 6 converts to unsigned 64-bit.
  - 7 is the bit move.

  A request accepted with in_valid high gives out_valid high and its result one cycle later. A cycle with in_valid low gives out_valid low on the next cycle, and out_result, out_nv and out_nx keep their values.
- R3: Equality returns 1 when neither operand is a NaN and the two values are equal, with +0 and -0 treated as equal. It returns 0 otherwise and never sets out_nx.
- R4: Less-than and less-or-equal return the numeric ordering as 0 or 1, with +0 equal to -0. If either operand is a NaN of any kind they return 0 and set out_nv. Otherwise out_nv is 0. Upper result bits 63:1 are 0 for all compares.
- R5: NaN encodings:
  - An operand with bits 30:23 all ones and bits 22:0 nonzero is a NaN.
  - It is signaling when bit 22 is 0 and quiet when bit 22 is 1.

  Equality sets out_nv exactly when an operand is a signaling NaN, and returns 0 for any NaN.
- R6: A finite input that is in range for its target gives the value truncated toward zero. out_nx is set when the input had a nonzero fraction, and out_nv stays 0.
- R7: A NaN converted to a signed target gives that target's largest positive value (0x7FFFFFFF or 0x7FFFFFFFFFFFFFFF) and sets out_nv.
- R8: A NaN converted to an unsigned target gives all ones in 64 bits and sets out_nv.
- R9: A negative nonzero input converted to an unsigned target gives 0 and sets out_nv, with out_nx clear. This covers inputs between -1 and 0, negative infinity and negative subnormals. An input of -0 gives 0 with no flag.
- R10: Saturation:
  - An input, including an infinity, whose truncated value is above the target maximum saturates to that maximum.
  - One below the target minimum saturates to that minimum.
  - Both cases set out_nv with out_nx clear.
  - The unsigned 32-bit maximum reads as all ones.
- R11: Both 32-bit conversions sign-extend their 32-bit result from bit 31 into the 64-bit output.
- R12: The bit move outputs in_a sign-extended from bit 31, with both flags clear.
- R13: sticky_nv and sticky_nx are the OR of out_nv and out_nx over all requests since reset, and never fall outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (see R2) |
| in_a | input | 32 | First operand, raw single-precision bits |
| in_b | input | 32 | Second operand, used by compares only |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | Integer result |
| out_nv | output | 1 | Invalid-operation flag of this result |
| out_nx | output | 1 | Inexact flag of this result |
| sticky_nv | output | 1 | Accumulated invalid flag |
| sticky_nx | output | 1 | Accumulated inexact flag |

## Verification
The bench sweeps every pair from a set of special patterns through all three compares: both zeros, subnormals, infinities, quiet and signaling NaNs of both signs, and values adjacent to each power-of-two limit. A design that treats the two zeros as ordered would report -0 < +0. A design that raises invalid on quiet NaNs during equality would set out_nv where none is due.

For conversions, the bench sweeps every exponent with several mantissas and both signs into all four targets. This catches saturation thresholds that are off by one at 2^31, 2^32 and 2^63. It also catches a missing sign extension of the 32-bit results, wrong NaN values for signed and unsigned targets, and an input such as -0.5 going to an unsigned target truncating to 0 silently instead of raising invalid.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int INT_W  = 64;
    localparam int NARROW = 32;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W  = MAN_W + 1;
    localparam int SH_W   = SIG_W + INT_W - 1;
    localparam int E_W    = EXP_W + 2;

    typedef enum logic [2:0] {
        OP_FEQ     = 3'd0,
        OP_FLT     = 3'd1,
        OP_FLE     = 3'd2,
        OP_CVT_S32 = 3'd3,
        OP_CVT_U32 = 3'd4,
        OP_CVT_S64 = 3'd5,
        OP_CVT_U64 = 3'd6,
        OP_MOVE    = 3'd7
    } fcc_op_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp32_t;

    typedef struct packed {
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } fp_class_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             nv;
        logic             nx;
    } fcc_res_t;

    function automatic logic [INT_W-1:0] sext32(logic [NARROW-1:0] v);
        return {{(INT_W-NARROW){v[NARROW-1]}}, v};
    endfunction

    function automatic logic is_narrow(fcc_op_e op);
        return (op == OP_CVT_S32) || (op == OP_CVT_U32);
    endfunction

    function automatic logic is_unsigned_tgt(fcc_op_e op);
        return (op == OP_CVT_U32) || (op == OP_CVT_U64);
    endfunction

    // value returned for a NaN input
    function automatic logic [INT_W-1:0] nan_value(fcc_op_e op);
        logic [INT_W-1:0] v;
        case (op)
            OP_CVT_S32: v = {{(INT_W-NARROW+1){1'b0}}, {(NARROW-1){1'b1}}};
            OP_CVT_S64: v = {1'b0, {(INT_W-1){1'b1}}};
            default:    v = {INT_W{1'b1}};
        endcase
        return v;
    endfunction

    // saturation value for an out-of-range input
    function automatic logic [INT_W-1:0] sat_value(fcc_op_e op, logic neg);
        logic [INT_W-1:0] v;
        case (op)
            OP_CVT_S32: v = neg ? sext32({1'b1, {(NARROW-1){1'b0}}})
                                : {{(INT_W-NARROW+1){1'b0}}, {(NARROW-1){1'b1}}};
            OP_CVT_S64: v = neg ? {1'b1, {(INT_W-1){1'b0}}}
                                : {1'b0, {(INT_W-1){1'b1}}};
            OP_CVT_U32: v = {INT_W{1'b1}};
            OP_CVT_U64: v = {INT_W{1'b1}};
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/fcc_classify.sv
module fcc_classify
    import fcc_pkg::*;
(
    input  fp32_t     opnd_i,
    output fp_class_t cls_o
);
    logic exp_ones;
    logic man_nz;

    always_comb begin
        exp_ones      = &opnd_i.exp;
        man_nz        = |opnd_i.man;
        cls_o.is_zero = (opnd_i.exp == '0) && !man_nz;
        cls_o.is_nan  = exp_ones && man_nz;
        // quiet bit is the top mantissa bit
        cls_o.is_snan = exp_ones && man_nz && !opnd_i.man[MAN_W-1];
    end
endmodule

// File: rtl/fcc_compare.sv
module fcc_compare
    import fcc_pkg::*;
(
    input  fp32_t     a_i,
    input  fp32_t     b_i,
    input  fp_class_t a_cls_i,
    input  fp_class_t b_cls_i,
    input  fcc_op_e   op_i,
    output fcc_res_t  res_o
);
    logic any_nan;
    logic any_snan;
    logic both_zero;
    logic mag_lt;
    logic mag_gt;
    logic eq;
    logic lt;

    always_comb begin
        any_nan   = a_cls_i.is_nan  || b_cls_i.is_nan;
        any_snan  = a_cls_i.is_snan || b_cls_i.is_snan;
        both_zero = a_cls_i.is_zero && b_cls_i.is_zero;
        mag_lt    = {a_i.exp, a_i.man} < {b_i.exp, b_i.man};
        mag_gt    = {a_i.exp, a_i.man} > {b_i.exp, b_i.man};
        eq        = both_zero || (a_i == b_i);

        if (both_zero)
            lt = 1'b0;
        else if (a_i.sign != b_i.sign)
            lt = a_i.sign;
        else if (a_i.sign)
            lt = mag_gt;
        else
            lt = mag_lt;

        res_o = '0;
        case (op_i)
            OP_FEQ: begin
                res_o.value[0] = eq && !any_nan;
                res_o.nv       = any_snan;
            end
            OP_FLT: begin
                res_o.value[0] = lt && !any_nan;
                res_o.nv       = any_nan;
            end
            OP_FLE: begin
                res_o.value[0] = (lt || eq) && !any_nan;
                res_o.nv       = any_nan;
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/fcc_convert.sv
module fcc_convert
    import fcc_pkg::*;
(
    input  fp32_t    a_i,
    input  logic     is_zero_i,
    input  logic     is_nan_i,
    input  fcc_op_e  op_i,
    output fcc_res_t res_o
);
    logic signed [E_W-1:0] unb_exp;
    logic [SIG_W-1:0]      sig;
    logic [SH_W-1:0]       shifted;
    logic                  exp_neg;
    logic                  big;
    logic [INT_W-1:0]      mag;
    logic [INT_W-1:0]      sval;
    logic                  frac_nz;
    logic                  ovf;
    logic                  neg;

    always_comb begin
        unb_exp = $signed({2'b00, a_i.exp}) - E_W'(BIAS);
        sig     = {(a_i.exp != '0), a_i.man};
        exp_neg = unb_exp[E_W-1];
        // exponents of 64 and above (including the all-ones code) cannot fit
        big     = !exp_neg && (|unb_exp[E_W-2:6]);
        shifted = {{(SH_W-SIG_W){1'b0}}, sig} << unb_exp[5:0];
        mag     = exp_neg ? '0 : shifted[SH_W-1:MAN_W];
        frac_nz = exp_neg ? !is_zero_i : (|shifted[MAN_W-1:0]);
        neg     = a_i.sign;
        sval    = neg ? (~mag + INT_W'(1)) : mag;

        case (op_i)
            OP_CVT_S32: ovf = neg ? ((|mag[INT_W-1:NARROW]) ||
                                     (mag[NARROW-1] && (|mag[NARROW-2:0])))
                                  : (|mag[INT_W-1:NARROW-1]);
            OP_CVT_U32: ovf = |mag[INT_W-1:NARROW];
            OP_CVT_S64: ovf = mag[INT_W-1] && (!neg || (|mag[INT_W-2:0]));
            default:    ovf = 1'b0;
        endcase
        ovf = ovf || big;

        res_o = '0;
        if (is_nan_i) begin
            res_o.value = nan_value(op_i);
            res_o.nv    = 1'b1;
        end else if (is_unsigned_tgt(op_i) && neg && !is_zero_i) begin
            res_o.value = '0;
            res_o.nv    = 1'b1;
        end else if (ovf) begin
            res_o.value = sat_value(op_i, neg);
            res_o.nv    = 1'b1;
        end else begin
            res_o.value = is_narrow(op_i) ? sext32(sval[NARROW-1:0]) : sval;
            res_o.nx    = frac_nz;
        end
    end
endmodule

// File: rtl/fcc_unit.sv
module fcc_unit
    import fcc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [2:0]  in_op,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    output logic        out_valid,
    output logic [63:0] out_result,
    output logic        out_nv,
    output logic        out_nx,
    output logic        sticky_nv,
    output logic        sticky_nx
);
    localparam int N_OPND = 2;

    fcc_op_e   op;
    fp32_t     opnd [N_OPND];
    fp_class_t cls  [N_OPND];
    fcc_res_t  cmp_res;
    fcc_res_t  cvt_res;
    fcc_res_t  sel;

    assign op      = fcc_op_e'(in_op);
    assign opnd[0] = fp32_t'(in_a);
    assign opnd[1] = fp32_t'(in_b);

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        fcc_classify u_cls (
            .opnd_i (opnd[g]),
            .cls_o  (cls[g])
        );
    end

    fcc_compare u_cmp (
        .a_i     (opnd[0]),
        .b_i     (opnd[1]),
        .a_cls_i (cls[0]),
        .b_cls_i (cls[1]),
        .op_i    (op),
        .res_o   (cmp_res)
    );

    fcc_convert u_cvt (
        .a_i       (opnd[0]),
        .is_zero_i (cls[0].is_zero),
        .is_nan_i  (cls[0].is_nan),
        .op_i      (op),
        .res_o     (cvt_res)
    );

    always_comb begin
        case (op)
            OP_FEQ, OP_FLT, OP_FLE: sel = cmp_res;
            OP_MOVE:                sel = '{value: sext32(in_a), nv: 1'b0, nx: 1'b0};
            default:                sel = cvt_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_nv     <= 1'b0;
            out_nx     <= 1'b0;
            sticky_nv  <= 1'b0;
            sticky_nx  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= sel.value;
                out_nv     <= sel.nv;
                out_nx     <= sel.nx;
                sticky_nv  <= sticky_nv | sel.nv;
                sticky_nx  <= sticky_nx | sel.nx;
            end
        end
    end
endmodule

// File: rtl/fcc_unit_chk.sv
module fcc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [2:0]  in_op,
    input logic [31:0] in_a,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic        out_nv,
    input logic        out_nx,
    input logic        sticky_nv,
    input logic        sticky_nx
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == 64'd0 && !out_nv && !out_nx &&
                 !sticky_nv && !sticky_nx));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_nv) &&
                       $stable(out_nx)));

    assert_cmp_bool_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op <= 3'd2) |=> (out_result[63:1] == 63'd0 && !out_nx));

    assert_flag_excl_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_nv && out_nx));

    assert_move_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd7) |=>
        (out_result == {{32{$past(in_a[31])}}, $past(in_a)} && !out_nv && !out_nx));

    assert_sticky_nv_hold_R13: assert property (@(posedge clk) disable iff (rst)
        sticky_nv |=> sticky_nv);

    assert_sticky_nx_hold_R13: assert property (@(posedge clk) disable iff (rst)
        sticky_nx |=> sticky_nx);

    assert_sticky_cover_R13: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((!out_nv || sticky_nv) && (!out_nx || sticky_nx)));
endmodule

bind fcc_unit fcc_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_nv     (out_nv),
    .out_nx     (out_nx),
    .sticky_nv  (sticky_nv),
    .sticky_nx  (sticky_nx)
);

// File: tb/fcc_unit_tb.sv
module fcc_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_PAT      = 37;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic [31:0] in_a = 32'd0;
    logic [31:0] in_b = 32'd0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_nv;
    logic        out_nx;
    logic        sticky_nv;
    logic        sticky_nx;

    int checks = 0;
    int failures = 0;
    logic exp_snv = 1'b0;
    logic exp_snx = 1'b0;
    logic [63:0] last_ev = 64'd0;
    logic last_nv = 1'b0;
    logic last_nx = 1'b0;

    fcc_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_nv(out_nv), .out_nx(out_nx),
        .sticky_nv(sticky_nv), .sticky_nx(sticky_nx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(int i);
        case (i)
            0:  return 32'h00000000;  1:  return 32'h80000000;
            2:  return 32'h3F800000;  3:  return 32'hBF800000;
            4:  return 32'h3F000000;  5:  return 32'hBF000000;
            6:  return 32'h3FC00000;  7:  return 32'hBFC00000;
            8:  return 32'h40200000;  9:  return 32'h00000001;
            10: return 32'h80000001;  11: return 32'h007FFFFF;
            12: return 32'h7F800000;  13: return 32'hFF800000;
            14: return 32'h7FC00000;  15: return 32'hFFC00001;
            16: return 32'h7F800001;  17: return 32'h7FA00000;
            18: return 32'hFF800010;  19: return 32'h4F000000;
            20: return 32'hCF000000;  21: return 32'h4EFFFFFF;
            22: return 32'h4F800000;  23: return 32'h4F7FFFFF;
            24: return 32'h5F000000;  25: return 32'hDF000000;
            26: return 32'h5EFFFFFF;  27: return 32'h5F800000;
            28: return 32'h5F7FFFFF;  29: return 32'h7F7FFFFF;
            30: return 32'hFF7FFFFF;  31: return 32'h40400000;
            32: return 32'hC0200000;  33: return 32'h42C98000;
            34: return 32'hBF7D70A4;  35: return 32'h4B7FFFFF;
            default: return 32'h3F7FFFFF;
        endcase
    endfunction

    function automatic logic f_nan(logic [31:0] f);
        return (f[30:23] == 8'hFF) && (f[22:0] != 23'd0);
    endfunction

    function automatic logic f_snan(logic [31:0] f);
        return f_nan(f) && !f[22];
    endfunction

    function automatic real to_real(logic [31:0] f);
        real r;
        int m;
        int ee;
        if (f[30:23] == 8'hFF) begin
            r = 1.0e300;
        end else begin
            m  = (f[30:23] == 8'd0) ? int'({9'd0, f[22:0]}) : int'({8'd0, 1'b1, f[22:0]});
            ee = (f[30:23] == 8'd0) ? 1 : int'({24'd0, f[30:23]});
            r  = real'(m) * $pow(2.0, real'(ee - 150));
        end
        return f[31] ? -r : r;
    endfunction

    task automatic calc(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        output logic [63:0] ev, output logic nv, output logic nx,
                        output string tag);
        real ra, rb, tr;
        logic an, bn, sgn, wide;
        longint v;
        ev = 64'd0; nv = 1'b0; nx = 1'b0; tag = "R2";
        an = f_nan(a); bn = f_nan(b);
        ra = to_real(a); rb = to_real(b);
        case (op)
            3'd0: begin
                ev = {63'd0, (!an && !bn && ra == rb)};
                nv = f_snan(a) || f_snan(b);
                tag = (an || bn) ? "R5" : "R3";
            end
            3'd1: begin
                ev = {63'd0, (!an && !bn && ra < rb)};
                nv = an || bn; tag = "R4";
            end
            3'd2: begin
                ev = {63'd0, (!an && !bn && ra <= rb)};
                nv = an || bn; tag = "R4";
            end
            3'd7: begin
                ev = {{32{a[31]}}, a}; tag = "R12";
            end
            default: begin
                sgn  = (op == 3'd3) || (op == 3'd5);
                wide = (op == 3'd5) || (op == 3'd6);
                tr = (ra < 0.0) ? $ceil(ra) : $floor(ra);
                if (an) begin
                    ev = sgn ? (wide ? 64'h7FFFFFFFFFFFFFFF : 64'h000000007FFFFFFF)
                             : 64'hFFFFFFFFFFFFFFFF;
                    nv = 1'b1; tag = sgn ? "R7" : "R8";
                end else if (!sgn && ra < 0.0) begin
                    ev = 64'd0; nv = 1'b1; tag = "R9";
                end else begin
                    case (op)
                        3'd3: begin
                            if (tr > 2147483647.0) begin
                                ev = 64'h000000007FFFFFFF; nv = 1'b1; tag = "R10";
                            end else if (tr < -2147483648.0) begin
                                ev = 64'hFFFFFFFF80000000; nv = 1'b1; tag = "R10";
                            end else begin
                                v = longint'(tr); ev = v; nx = (tr != ra); tag = "R11";
                            end
                        end
                        3'd4: begin
                            if (tr > 4294967295.0) begin
                                ev = 64'hFFFFFFFFFFFFFFFF; nv = 1'b1; tag = "R10";
                            end else begin
                                v = longint'(tr); ev = {{32{v[31]}}, v[31:0]};
                                nx = (tr != ra); tag = "R11";
                            end
                        end
                        3'd5: begin
                            if (tr >= 9223372036854775808.0) begin
                                ev = 64'h7FFFFFFFFFFFFFFF; nv = 1'b1; tag = "R10";
                            end else if (tr < -9223372036854775808.0) begin
                                ev = 64'h8000000000000000; nv = 1'b1; tag = "R10";
                            end else begin
                                v = longint'(tr); ev = v; nx = (tr != ra); tag = "R6";
                            end
                        end
                        default: begin
                            if (tr >= 18446744073709551616.0) begin
                                ev = 64'hFFFFFFFFFFFFFFFF; nv = 1'b1; tag = "R10";
                            end else if (tr >= 9223372036854775808.0) begin
                                v = longint'(tr - 9223372036854775808.0);
                                ev = {1'b1, v[62:0]}; tag = "R6";
                            end else begin
                                v = longint'(tr); ev = v; nx = (tr != ra); tag = "R6";
                            end
                        end
                    endcase
                end
            end
        endcase
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ev;
        logic nv, nx;
        string tag;
        calc(op, a, b, ev, nv, nx, tag);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || out_result !== ev || out_nv !== nv || out_nx !== nx) begin
            failures++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h nv=%b nx=%b v=%b expected=%h nv=%b nx=%b v=1",
                     tag, op, a, b, out_result, out_nv, out_nx, out_valid, ev, nv, nx);
        end
        exp_snv = exp_snv | nv;
        exp_snx = exp_snx | nx;
        last_ev = ev; last_nv = nv; last_nx = nx;
        checks++;
        if (sticky_nv !== exp_snv || sticky_nx !== exp_snx) begin
            failures++;
            $display("FAIL R13 sticky actual=%b%b expected=%b%b", sticky_nv, sticky_nx,
                     exp_snv, exp_snx);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || out_result !== 64'd0 || out_nv !== 1'b0 ||
            out_nx !== 1'b0 || sticky_nv !== 1'b0 || sticky_nx !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%b %h %b %b %b %b expected=0 0 0 0 0 0",
                     out_valid, out_result, out_nv, out_nx, sticky_nv, sticky_nx);
        end
        rst = 1'b0;

        // R12 bit move over every pattern
        for (int i = 0; i < N_PAT; i++) run_op(3'd7, pat(i), 32'h0);

        // R3 R4 R5 compares over all pattern pairs
        for (int op = 0; op < 3; op++)
            for (int i = 0; i < N_PAT; i++)
                for (int j = 0; j < N_PAT; j++)
                    run_op(op[2:0], pat(i), pat(j));

        // R6 to R11 conversions of special patterns
        for (int op = 3; op < 7; op++)
            for (int i = 0; i < N_PAT; i++)
                run_op(op[2:0], pat(i), 32'h0);

        // exponent sweep for thresholds
        for (int op = 3; op < 7; op++)
            for (int e = 0; e < 256; e++)
                for (int k = 0; k < 5; k++)
                    for (int s = 0; s < 2; s++) begin
                        logic [22:0] m;
                        int mix;
                        mix = e * 40503 + k * 977 + 12345;
                        case (k)
                            0: m = 23'h000000;
                            1: m = 23'h400000;
                            2: m = 23'h000001;
                            3: m = 23'h7FFFFF;
                            default: m = mix[22:0];
                        endcase
                        run_op(op[2:0], {s[0], e[7:0], m}, 32'h0);
                    end

        // R2 idle cycles: outputs hold, valid falls, inputs ignored
        in_valid = 1'b0; in_op = 3'd3; in_a = 32'h7F800001;
        repeat (2) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_result !== last_ev || out_nv !== last_nv ||
                out_nx !== last_nx) begin
                failures++;
                $display("FAIL R2 idle actual=%b %h %b %b expected=0 %h %b %b",
                         out_valid, out_result, out_nv, out_nx, last_ev, last_nv, last_nx);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule